// File: doc/BRIEF.md
# Tiny 8-bit multi-cycle processor core

This block is a small sequential processor. It reads a byte-coded program from an external byte-wide memory through a 16-bit address and an 8-bit data bus, and executes it one instruction at a time. Its programmer-visible state is four 8-bit general registers (A, B, C, D), a 16-bit program counter, and a zero flag and a carry/borrow flag. The instruction set has seven members: load a register from an immediate, add or subtract two registers, jump, jump on zero, jump on non-zero, and halt. Instructions are three bytes long except halt, which is one byte.

The memory answers with a fixed latency of one clock: the byte at the address driven in one cycle appears on the read data input in the next cycle. Each three-byte instruction takes five cycles. An observation port shows the program counter, the fetched opcode, all registers and both flags whenever an instruction is about to execute. In single-step mode the core waits at that point until it sees a step request. A halt instruction, an unknown opcode or a bad register index stops the core for good until reset.

Top module: `tiny8_core`

## Requirements
- R1: While `rst` is high and after its release: PC = 0x0000, all registers 0, Z = C = 0, `halted` = 0, `illegal` = 0, `mem_addr` = 0x0000.
- R2: Opcode 0x01 is a load, laid out as [0x01, index, value]. It writes value to the register selected by index (0 = A, 1 = B, 2 = C, 3 = D). The next instruction is at PC+3.
- R3: Opcode 0x02 is an add, laid out as [0x02, dst, src]. It computes dst = dst + src mod 256. C is set to the carry out of bit 7 and Z to (result == 0).
- R4: Opcode 0x03 is a subtract, laid out as [0x03, dst, src]. It computes dst = dst - src mod 256. C is set to (dst < src) as unsigned values and Z to (result == 0).
- R5: Loads and all jumps leave Z and C unchanged.
- R6: Opcodes 0x04 (always), 0x05 (taken when Z = 1) and 0x06 (taken when Z = 0) are laid out as [op, target low byte, target high byte]. A taken jump continues at that target. A jump that is not taken continues at PC+3.
- R7: Opcode 0xFF raises `halted`. After that `halted` stays high, `mem_addr` stays frozen, and `trace_valid` stays low until reset.
- R8: An opcode outside {0x01..0x06, 0xFF}, or a register index above 3 in a load, add or subtract, raises both `illegal` and `halted` and changes no register or flag.
- R9: With `step_mode` = 1, the core holds `trace_valid` high with unchanged trace contents until `step_req` is sampled high. Each such one-cycle pulse executes exactly one instruction.
- R10: With `step_mode` = 0, `trace_valid` is high for one cycle per executed (non-halting) instruction. In that cycle `trace_pc` is the instruction's address, `trace_op` its opcode, and `trace_regs` (A in bits 7:0 up to D in bits 31:24) and `trace_z`/`trace_c` hold the state before it executes. `mem_rdata` is taken to be the byte at the previous cycle's `mem_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Registered program memory address |
| mem_rdata | input | 8 | Byte at previous cycle's address |
| step_mode | input | 1 | 1 = wait for a step request before each instruction |
| step_req | input | 1 | One-cycle pulse releasing one instruction |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Stop was caused by a bad opcode or register index |
| trace_valid | output | 1 | Trace fields describe the instruction about to run |
| trace_pc | output | 16 | Program counter |
| trace_op | output | 8 | Fetched opcode |
| trace_regs | output | 32 | Registers D:C:B:A |
| trace_z | output | 1 | Zero flag |
| trace_c | output | 1 | Carry/borrow flag |

## Verification
Randomly generated programs mix loads, adds, subtracts and forward conditional and unconditional jumps. A bench instruction model checks every trace snapshot, so wrong register routing, flag logic or branch direction shows up as a divergence at the very next instruction. Directed programs cover specific corners:
- a jump to 0x0F00, which tells the low/high byte order apart;
- an add wrapping to zero, which sets Z and C together, followed by a load that must not disturb them;
- a subtract that borrows;
- an unknown opcode and an out-of-range register index.

A countdown loop run in step mode checks that the trace is held between pulses and that each pulse advances exactly one instruction.

// File: rtl/tiny8_pkg.sv
package tiny8_pkg;
  localparam logic [7:0] OP_LDI = 8'h01;
  localparam logic [7:0] OP_ADD = 8'h02;
  localparam logic [7:0] OP_SUB = 8'h03;
  localparam logic [7:0] OP_JMP = 8'h04;
  localparam logic [7:0] OP_JZ  = 8'h05;
  localparam logic [7:0] OP_JNZ = 8'h06;
  localparam logic [7:0] OP_HLT = 8'hFF;

  typedef enum logic [2:0] {
    ST_ADDR,   // address of opcode on the bus
    ST_OPC,    // opcode arrives
    ST_HOLD,   // trace window / step gate
    ST_B1,     // first operand byte arrives
    ST_B2,     // second operand byte arrives, execute
    ST_STOP    // halted
  } state_t;
endpackage

// File: rtl/tiny8_regfile.sv
module tiny8_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 4,
  localparam int IW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IW-1:0]      waddr,
  input  logic [DW-1:0]      wdata,
  input  logic [IW-1:0]      ra0,
  input  logic [IW-1:0]      ra1,
  output logic [DW-1:0]      rd0,
  output logic [DW-1:0]      rd1,
  output logic [NREG*DW-1:0] flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] r;
    always_ff @(posedge clk) begin
      if (rst)                           r <= '0;
      else if (we && waddr == IW'(g))    r <= wdata;
    end
    assign flat[g*DW +: DW] = r;
  end

  assign rd0 = flat[ra0*DW +: DW];
  assign rd1 = flat[ra1*DW +: DW];
endmodule

// File: rtl/tiny8_alu.sv
module tiny8_alu #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] res,
  output logic          cout,
  output logic          zero
);
  always_comb begin
    if (sub) begin
      res  = a - b;
      cout = (a < b);
    end else begin
      {cout, res} = {1'b0, a} + {1'b0, b};
    end
    zero = (res == '0);
  end
endmodule

// File: rtl/tiny8_core.sv
module tiny8_core
  import tiny8_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int NREG = 4
) (
  input  logic               clk,
  input  logic               rst,
  output logic [AW-1:0]      mem_addr,
  input  logic [DW-1:0]      mem_rdata,
  input  logic               step_mode,
  input  logic               step_req,
  output logic               halted,
  output logic               illegal,
  output logic               trace_valid,
  output logic [AW-1:0]      trace_pc,
  output logic [DW-1:0]      trace_op,
  output logic [NREG*DW-1:0] trace_regs,
  output logic               trace_z,
  output logic               trace_c
);
  localparam int IW = $clog2(NREG);
  localparam logic [AW-1:0] ONE  = AW'(1);
  localparam logic [AW-1:0] TWO  = AW'(2);
  localparam logic [AW-1:0] ILEN = AW'(3);

  state_t        st;
  logic [AW-1:0] pc;
  logic [DW-1:0] op_q, b1_q;
  logic          z_q, c_q;

  // decode
  logic is_ldi, is_add, is_sub, is_alu, is_jmp, is_jz, is_jnz, is_hlt, known;
  assign is_ldi = (op_q == DW'(OP_LDI));
  assign is_add = (op_q == DW'(OP_ADD));
  assign is_sub = (op_q == DW'(OP_SUB));
  assign is_jmp = (op_q == DW'(OP_JMP));
  assign is_jz  = (op_q == DW'(OP_JZ));
  assign is_jnz = (op_q == DW'(OP_JNZ));
  assign is_alu = is_add | is_sub;

  logic [DW-1:0] rdop;
  assign rdop   = mem_rdata;
  assign is_hlt = (rdop == DW'(OP_HLT));
  assign known  = (rdop == DW'(OP_LDI)) || (rdop == DW'(OP_ADD)) ||
                  (rdop == DW'(OP_SUB)) || (rdop == DW'(OP_JMP)) ||
                  (rdop == DW'(OP_JZ))  || (rdop == DW'(OP_JNZ));

  logic idx_ok;
  assign idx_ok = (mem_rdata < DW'(NREG));

  // datapath
  logic [DW-1:0] rd0, rd1, alu_res;
  logic          alu_c, alu_z, rf_we;
  logic [DW-1:0] rf_wdata;

  tiny8_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (rf_we),
    .waddr (b1_q[IW-1:0]),
    .wdata (rf_wdata),
    .ra0   (b1_q[IW-1:0]),
    .ra1   (mem_rdata[IW-1:0]),
    .rd0   (rd0),
    .rd1   (rd1),
    .flat  (trace_regs)
  );

  tiny8_alu #(.DW(DW)) u_alu (
    .a    (rd0),
    .b    (rd1),
    .sub  (is_sub),
    .res  (alu_res),
    .cout (alu_c),
    .zero (alu_z)
  );

  logic [AW-1:0] tgt, npc;
  logic          take;
  assign tgt      = AW'({mem_rdata, b1_q});
  assign take     = is_jmp | (is_jz & z_q) | (is_jnz & ~z_q);
  assign npc      = take ? tgt : pc + ILEN;
  assign rf_we    = (st == ST_B2) && (is_ldi || (is_alu && idx_ok));
  assign rf_wdata = is_ldi ? mem_rdata : alu_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_ADDR;
      pc       <= '0;
      mem_addr <= '0;
      op_q     <= '0;
      b1_q     <= '0;
      z_q      <= 1'b0;
      c_q      <= 1'b0;
      halted   <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      case (st)
        ST_ADDR: begin
          mem_addr <= pc + ONE;
          st       <= ST_OPC;
        end
        ST_OPC: begin
          op_q <= mem_rdata;
          if (is_hlt) begin
            halted <= 1'b1;
            st     <= ST_STOP;
          end else if (!known) begin
            halted  <= 1'b1;
            illegal <= 1'b1;
            st      <= ST_STOP;
          end else begin
            st <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (!step_mode || step_req) begin
            mem_addr <= pc + TWO;
            st       <= ST_B1;
          end
        end
        ST_B1: begin
          b1_q <= mem_rdata;
          if ((is_ldi || is_alu) && !idx_ok) begin
            halted  <= 1'b1;
            illegal <= 1'b1;
            st      <= ST_STOP;
          end else begin
            st <= ST_B2;
          end
        end
        ST_B2: begin
          if (is_alu && !idx_ok) begin
            halted  <= 1'b1;
            illegal <= 1'b1;
            st      <= ST_STOP;
          end else begin
            pc       <= npc;
            mem_addr <= npc;
            st       <= ST_ADDR;
            if (is_alu) begin
              z_q <= alu_z;
              c_q <= alu_c;
            end
          end
        end
        default: st <= ST_STOP;
      endcase
    end
  end

  assign trace_valid = (st == ST_HOLD);
  assign trace_pc    = pc;
  assign trace_op    = op_q;
  assign trace_z     = z_q;
  assign trace_c     = c_q;
endmodule

// File: rtl/tiny8_core_chk.sv
module tiny8_core_chk #(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int NREG = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [AW-1:0]      mem_addr,
  input logic               step_mode,
  input logic               step_req,
  input logic               halted,
  input logic               illegal,
  input logic               trace_valid,
  input logic [AW-1:0]      trace_pc,
  input logic [NREG*DW-1:0] trace_regs,
  input logic               trace_z,
  input logic               trace_c
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (trace_pc == '0 && mem_addr == '0 && trace_regs == '0 &&
                    !trace_z && !trace_c && !halted && !illegal));

  a_r7_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  a_r7_no_fetch: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(mem_addr) && !trace_valid));

  a_r8_illegal_halts: assert property (@(posedge clk) disable iff (rst)
    illegal |-> halted);

  a_r9_step_hold: assert property (@(posedge clk) disable iff (rst)
    (trace_valid && step_mode && !step_req) |=>
      (trace_valid && $stable(trace_pc) && $stable(trace_regs)));

  a_r10_single_trace: assert property (@(posedge clk) disable iff (rst)
    (trace_valid && !step_mode) |=> !trace_valid);
endmodule

bind tiny8_core tiny8_core_chk #(.AW(AW), .DW(DW), .NREG(NREG)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mem_addr    (mem_addr),
  .step_mode   (step_mode),
  .step_req    (step_req),
  .halted      (halted),
  .illegal     (illegal),
  .trace_valid (trace_valid),
  .trace_pc    (trace_pc),
  .trace_regs  (trace_regs),
  .trace_z     (trace_z),
  .trace_c     (trace_c)
);

// File: tb/tb_tiny8_core.sv
module tb_tiny8_core;
  localparam int CLK_PERIOD = 10;
  localparam int MEMW       = 12;
  localparam int WDOG       = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;
  logic        step_mode = 1'b0;
  logic        step_req  = 1'b0;
  logic        halted, illegal, trace_valid, trace_z, trace_c;
  logic [15:0] trace_pc;
  logic [7:0]  trace_op;
  logic [31:0] trace_regs;

  always #(CLK_PERIOD/2) clk = ~clk;

  tiny8_core dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .step_mode(step_mode), .step_req(step_req), .halted(halted),
    .illegal(illegal), .trace_valid(trace_valid), .trace_pc(trace_pc),
    .trace_op(trace_op), .trace_regs(trace_regs), .trace_z(trace_z),
    .trace_c(trace_c)
  );

  logic [7:0] mem [1<<MEMW];
  always @(posedge clk) mem_rdata <= mem[mem_addr[MEMW-1:0]];

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc == WDOG) begin
      checks++; errors++;
      $display("FAIL R10 watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bench instruction model
  logic [15:0] m_pc;
  logic [7:0]  m_r [4];
  bit          m_z, m_c, m_halt, m_ill;
  logic [7:0]  last_op;

  function automatic logic [7:0] rd(input logic [15:0] a);
    return mem[a[MEMW-1:0]];
  endfunction

  task automatic ref_step();
    logic [7:0] op, b1, b2, res;
    logic [15:0] tgt;
    op = rd(m_pc); b1 = rd(m_pc + 16'd1); b2 = rd(m_pc + 16'd2);
    tgt = {b2, b1};
    last_op = op;
    case (op)
      8'h01: if (b1 > 3) m_ill = 1; else begin m_r[b1[1:0]] = b2; m_pc += 3; end
      8'h02, 8'h03: begin
        if (b1 > 3 || b2 > 3) m_ill = 1;
        else begin
          if (op == 8'h02) begin
            {m_c, res} = {1'b0, m_r[b1[1:0]]} + {1'b0, m_r[b2[1:0]]};
          end else begin
            res = m_r[b1[1:0]] - m_r[b2[1:0]];
            m_c = m_r[b1[1:0]] < m_r[b2[1:0]];
          end
          m_z = (res == 8'h00);
          m_r[b1[1:0]] = res;
          m_pc += 3;
        end
      end
      8'h04: m_pc = tgt;
      8'h05: m_pc = m_z ? tgt : m_pc + 16'd3;
      8'h06: m_pc = !m_z ? tgt : m_pc + 16'd3;
      8'hFF: m_halt = 1;
      default: m_ill = 1;
    endcase
    if (m_ill) m_halt = 1;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < (1<<MEMW); i++) mem[i] = 8'hFF;
  endtask

  task automatic put3(input int a, input int x, input int y, input int z);
    mem[a]   = 8'(x);
    mem[a+1] = 8'(y);
    mem[a+2] = 8'(z);
  endtask

  task automatic cmp_regs(input string tag);
    for (int i = 0; i < 4; i++)
      chk(trace_regs[i*8 +: 8] == m_r[i], tag, "register",
          int'(trace_regs[i*8 +: 8]), int'(m_r[i]));
  endtask

  task automatic run_prog(input bit stepm);
    string rt, ft, pt;
    logic [15:0] a0;
    step_mode = stepm; step_req = 0; rst = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(trace_pc == 16'h0 && mem_addr == 16'h0, "R1", "pc/addr", int'(trace_pc), 0);
    chk(trace_regs == 32'h0 && !trace_z && !trace_c, "R1", "regs/flags",
        int'(trace_regs), 0);
    chk(!halted && !illegal && !trace_valid, "R1", "status",
        int'({halted, illegal, trace_valid}), 0);
    m_pc = 0; m_z = 0; m_c = 0; m_halt = 0; m_ill = 0; last_op = 0;
    for (int i = 0; i < 4; i++) m_r[i] = 0;
    rst = 0;
    forever begin
      @(negedge clk);
      if (halted) break;
      if (trace_valid) begin
        pt = stepm ? "R9" : ((last_op >= 8'h04 && last_op <= 8'h06) ? "R6" : "R10");
        case (last_op)
          8'h00: rt = "R1";
          8'h01: rt = "R2";
          8'h02: rt = "R3";
          8'h03: rt = "R4";
          default: rt = "R6";
        endcase
        ft = (last_op == 8'h02) ? "R3" : (last_op == 8'h03) ? "R4" :
             (last_op == 8'h00) ? "R1" : "R5";
        chk(trace_pc == m_pc, pt, "trace pc", int'(trace_pc), int'(m_pc));
        chk(trace_op == rd(m_pc), "R10", "trace opcode", int'(trace_op), int'(rd(m_pc)));
        cmp_regs(rt);
        chk({trace_z, trace_c} == {m_z, m_c}, ft, "flags Z,C",
            int'({trace_z, trace_c}), int'({m_z, m_c}));
        ref_step();
        if (stepm) begin
          a0 = trace_pc;
          repeat (3) @(negedge clk);
          chk(trace_valid && trace_pc == a0, "R9", "hold without step",
              int'(trace_pc), int'(a0));
          step_req = 1;
          @(negedge clk);
          step_req = 0;
          chk(!trace_valid, "R9", "released after pulse", int'(trace_valid), 0);
        end
      end
    end
    if (!m_halt) ref_step();
    chk(halted == 1'b1 && m_halt, "R7", "halted", int'(halted), 1);
    chk(illegal == m_ill, "R8", "illegal flag", int'(illegal), int'(m_ill));
    cmp_regs(m_ill ? "R8" : "R7");
    chk({trace_z, trace_c} == {m_z, m_c}, m_ill ? "R8" : "R7", "final flags",
        int'({trace_z, trace_c}), int'({m_z, m_c}));
    a0 = mem_addr;
    repeat (4) @(negedge clk);
    chk(mem_addr == a0 && !trace_valid && halted, "R7", "frozen after stop",
        int'(mem_addr), int'(a0));
  endtask

  task automatic gen_random(input int n);
    int kind, t;
    clear_mem();
    for (int k = 0; k < n; k++) begin
      kind = int'($urandom % 7);
      case (kind)
        0, 1: put3(3*k, 1, int'($urandom % 4), int'($urandom % 256));
        2:    put3(3*k, 2, int'($urandom % 4), int'($urandom % 4));
        3:    put3(3*k, 3, int'($urandom % 4), int'($urandom % 4));
        default: begin
          t = 3 * (k + 1 + int'($urandom % 3));
          if (t > 3*n) t = 3*n;
          put3(3*k, kind, t & 255, t >> 8);
        end
      endcase
    end
  endtask

  initial begin
    int seed;
    seed = int'($urandom(7731));
    // R6: little-endian jump target 0x0F00
    clear_mem();
    put3(0, 4, 8'h00, 8'h0F);
    put3(16'h0F00, 1, 0, 8'h5A);
    run_prog(0);
    chk(trace_regs[7:0] == 8'h5A, "R6", "jump landed at 0x0F00", int'(trace_regs[7:0]), 8'h5A);
    // R3/R5: add wraps to zero, then load keeps flags
    clear_mem();
    put3(0, 1, 0, 8'hF0); put3(3, 1, 1, 8'h10); put3(6, 2, 0, 1);
    put3(9, 1, 2, 8'h07); put3(12, 5, 18, 0); put3(15, 1, 3, 8'hEE);
    run_prog(0);
    chk(trace_z && trace_c, "R3", "add carry and zero", int'({trace_z, trace_c}), 3);
    chk(trace_regs[31:24] == 8'h00, "R5", "jz taken skipped load", int'(trace_regs[31:24]), 0);
    // R4: subtract with borrow, jnz taken
    clear_mem();
    put3(0, 1, 0, 1); put3(3, 1, 1, 2); put3(6, 3, 0, 1); put3(9, 6, 15, 0);
    put3(12, 1, 2, 8'h33);
    run_prog(0);
    chk(trace_regs[7:0] == 8'hFF && trace_c && !trace_z, "R4", "borrow",
        int'(trace_regs[7:0]), 8'hFF);
    // R8: unknown opcode
    clear_mem();
    put3(0, 1, 1, 8'h44); mem[3] = 8'h07;
    run_prog(0);
    // R8: register index out of range in source
    clear_mem();
    put3(0, 1, 0, 8'h12); put3(3, 2, 0, 5);
    run_prog(0);
    // R8: register index out of range in load
    clear_mem();
    put3(0, 1, 4, 8'h99);
    run_prog(0);
    // R9: countdown loop in single-step mode
    clear_mem();
    put3(0, 1, 1, 3); put3(3, 1, 0, 1); put3(6, 3, 1, 0); put3(9, 6, 6, 0);
    run_prog(1);
    chk(trace_regs[15:8] == 8'h00 && trace_z, "R9", "loop result", int'(trace_regs[15:8]), 0);
    // random programs, some stepped
    for (int p = 0; p < 30; p++) begin
      gen_random(5 + int'($urandom % 20));
      run_prog(p % 6 == 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule